// File: doc/BRIEF.md
# Execute-Stage Link and Result Selection

This block is the execute-stage datapath of a five-stage pipeline with a one-slot delayed branch. It takes the operands already forwarded in the decode stage, the extended immediate, the PC+4 value carried down the pipe, a 4-bit ALU operation code and three flags (shift, immediate-select, link). From these it forms the two ALU operands, runs a small ALU and produces the stage result and destination register number. Both are held in the stage output register that feeds the memory stage.

A call instruction (jump-and-link) is completed here. A dedicated adder forms PC+8 from the incoming PC+4. PC+8 replaces the ALU result and the destination is forced to register 31. The return address skips PC+4 because the instruction in the delay slot has already run by the time control transfers. For shift instructions the shift amount comes from the shamt field of the immediate, not from a register.

Top module: `exeLinkStage`

## Requirements
- R1: While `rstN` is low, `exeResult` and `exeDest` are both zero.
- R2: Each rising clock edge with `rstN` high captures the inputs. The matching result and destination appear on the outputs after that edge and hold until the next edge.
- R3: When `isLink` is 1, the result is `pcPlus4 + 4` and the destination is 31, whatever the operation code, operands or `dstIn`. A call at address 0x08 (`pcPlus4` = 0x0C) gives 0x10.
- R4: When `isLink` is 0, the destination is `dstIn`.
- R5: ALU operand B is `immExt` when `useImm` is 1, and `opB` otherwise.
- R6: When `isShift` is 1, ALU operand A is `immExt[10:6]` zero-extended and `opA` is ignored. Otherwise operand A is `opA`. The shifts use the low 5 bits of operand A as the amount.
- R7: Code 0 adds A+B and code 1 subtracts A−B. Both wrap modulo 2^32.
- R8: Code 2 gives bitwise AND, code 3 bitwise OR and code 4 bitwise XOR of A and B.
- R9: Code 5 (load upper) gives operand B shifted left by 16, with the low half zero.
- R10: Code 6 shifts B left logically, code 7 shifts B right and zero-fills, and code 8 shifts B right and copies the sign bit. All three shift by the amount from R6.
- R11: Codes 9 to 15 give a zero result when `isLink` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcPlus4 | input | 32 | PC+4 of the instruction in execute |
| opA | input | 32 | Forwarded first source operand |
| opB | input | 32 | Forwarded second source operand |
| immExt | input | 32 | Extended immediate field |
| aluCode | input | 4 | ALU operation code |
| isShift | input | 1 | Take operand A from the shamt field |
| useImm | input | 1 | Take operand B from the immediate |
| isLink | input | 1 | Call: result is PC+8, destination is 31 |
| dstIn | input | 5 | Decoded destination register (rd or rt) |
| exeResult | output | 32 | Registered stage result |
| exeDest | output | 5 | Registered destination register number |

## Verification
The link override is the hardest case to observe. Ordinary traffic never pairs a call with a live ALU code or a non-31 destination, so a broken priority would go unseen. The stimulus sends calls that carry a subtract code, non-trivial operands and a stray `dstIn`, and expects PC+8 and 31 to win. A second hard case is the shift-amount source. Shifts are driven with a large `opA` that would give a different amount, so a design that reads the register operand fails. Arithmetic shift is driven with the sign bit set so that zero-fill and sign-fill give different results.

// File: rtl/exeLinkPkg.sv
package exeLinkPkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_LUI = 4'd5,
    OP_SLL = 4'd6,
    OP_SRL = 4'd7,
    OP_SRA = 4'd8,
    OP_NONE = 4'd15
  } aluOpT;

  typedef struct packed {
    aluOpT aluOp;
    logic  selShiftA;
    logic  selImmB;
    logic  selLink;
  } exeStrobesT;

endpackage

// File: rtl/exeControl.sv
module exeControl
  import exeLinkPkg::*;
(
  input  logic [3:0] aluCode,
  input  logic       isShift,
  input  logic       useImm,
  input  logic       isLink,
  output exeStrobesT strobes
);

  aluOpT opDecoded;

  always_comb begin
    case (aluCode)
      4'd0:    opDecoded = OP_ADD;
      4'd1:    opDecoded = OP_SUB;
      4'd2:    opDecoded = OP_AND;
      4'd3:    opDecoded = OP_OR;
      4'd4:    opDecoded = OP_XOR;
      4'd5:    opDecoded = OP_LUI;
      4'd6:    opDecoded = OP_SLL;
      4'd7:    opDecoded = OP_SRL;
      4'd8:    opDecoded = OP_SRA;
      default: opDecoded = OP_NONE;
    endcase
  end

  always_comb begin
    strobes.aluOp     = opDecoded;
    strobes.selShiftA = isShift;
    strobes.selImmB   = useImm;
    strobes.selLink   = isLink;
  end

endmodule

// File: rtl/exeDatapath.sv
module exeDatapath
  import exeLinkPkg::*;
#(
  parameter int W       = 32,
  parameter int RW      = 5,
  parameter int SAHI    = 10,
  parameter int SALO    = 6,
  parameter int LINKREG = 31
) (
  input  logic          clk,
  input  logic          rstN,
  input  exeStrobesT    strobes,
  input  logic [W-1:0]  pcPlus4,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [W-1:0]  immExt,
  input  logic [RW-1:0] dstIn,
  output logic [W-1:0]  exeResult,
  output logic [RW-1:0] exeDest
);

  localparam int SAW   = SAHI - SALO + 1;
  localparam int SHW   = $clog2(W);
  localparam int HALFW = W / 2;

  logic [W-1:0]   aluA;
  logic [W-1:0]   aluB;
  logic [SHW-1:0] shamt;
  logic [W-1:0]   aluOut;
  logic [W-1:0]   linkAddr;
  logic [W-1:0]   nextResult;
  logic [RW-1:0]  nextDest;

  always_comb begin
    aluA  = strobes.selShiftA ? {{(W-SAW){1'b0}}, immExt[SAHI:SALO]} : opA;
    aluB  = strobes.selImmB ? immExt : opB;
    shamt = aluA[SHW-1:0];
  end

  assign linkAddr = pcPlus4 + W'(4);

  always_comb begin
    case (strobes.aluOp)
      OP_ADD:  aluOut = aluA + aluB;
      OP_SUB:  aluOut = aluA - aluB;
      OP_AND:  aluOut = aluA & aluB;
      OP_OR:   aluOut = aluA | aluB;
      OP_XOR:  aluOut = aluA ^ aluB;
      OP_LUI:  aluOut = aluB << HALFW;
      OP_SLL:  aluOut = aluB << shamt;
      OP_SRL:  aluOut = aluB >> shamt;
      OP_SRA:  aluOut = W'($signed(aluB) >>> shamt);
      default: aluOut = '0;
    endcase
  end

  always_comb begin
    if (strobes.selLink) begin
      nextResult = linkAddr;
      nextDest   = RW'(LINKREG);
    end else begin
      nextResult = aluOut;
      nextDest   = dstIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exeResult <= '0;
      exeDest   <= '0;
    end else begin
      exeResult <= nextResult;
      exeDest   <= nextDest;
    end
  end

endmodule

// File: rtl/exeLinkStage.sv
module exeLinkStage
  import exeLinkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] pcPlus4,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] immExt,
  input  logic [3:0]  aluCode,
  input  logic        isShift,
  input  logic        useImm,
  input  logic        isLink,
  input  logic [4:0]  dstIn,
  output logic [31:0] exeResult,
  output logic [4:0]  exeDest
);

  exeStrobesT strobes;

  exeControl u_ctrl (
    .aluCode (aluCode),
    .isShift (isShift),
    .useImm  (useImm),
    .isLink  (isLink),
    .strobes (strobes)
  );

  exeDatapath #(
    .W(32), .RW(5), .SAHI(10), .SALO(6), .LINKREG(31)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pcPlus4   (pcPlus4),
    .opA       (opA),
    .opB       (opB),
    .immExt    (immExt),
    .dstIn     (dstIn),
    .exeResult (exeResult),
    .exeDest   (exeDest)
  );

endmodule

// File: rtl/exeLinkStageChecker.sv
module exeLinkStageChecker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] pcPlus4,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] immExt,
  input logic [3:0]  aluCode,
  input logic        isShift,
  input logic        useImm,
  input logic        isLink,
  input logic [4:0]  dstIn,
  input logic [31:0] exeResult,
  input logic [4:0]  exeDest
);

  // Set once one edge has captured live inputs, so $past refers to them.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_link_override_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(isLink)) |->
      (exeDest == 5'd31 && exeResult == $past(pcPlus4) + 32'd4));

  assert_dest_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(isLink)) |-> (exeDest == $past(dstIn)));

  assert_add_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(isLink) && !$past(isShift) && $past(aluCode) == 4'd0) |->
      (exeResult == $past(opA) + ($past(useImm) ? $past(immExt) : $past(opB))));

  assert_lui_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(isLink) && $past(useImm) && $past(aluCode) == 4'd5) |->
      (exeResult == {$past(immExt[15:0]), 16'h0000}));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(isLink) && $past(aluCode) > 4'd8) |-> (exeResult == 32'd0));

endmodule

bind exeLinkStage exeLinkStageChecker chk (
  .clk(clk), .rstN(rstN), .pcPlus4(pcPlus4), .opA(opA), .opB(opB),
  .immExt(immExt), .aluCode(aluCode), .isShift(isShift), .useImm(useImm),
  .isLink(isLink), .dstIn(dstIn), .exeResult(exeResult), .exeDest(exeDest)
);

// File: tb/exeLinkStage_test.sv
`timescale 1ns/1ps
module exeLinkStage_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pcPlus4 = '0, opA = '0, opB = '0, immExt = '0;
  logic [3:0]  aluCode = '0;
  logic        isShift = 1'b0, useImm = 1'b0, isLink = 1'b0;
  logic [4:0]  dstIn = '0;
  logic [31:0] exeResult;
  logic [4:0]  exeDest;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] expResQ[$];
  logic [4:0]  expDstQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  exeLinkStage uut (
    .clk(clk), .rstN(rstN), .pcPlus4(pcPlus4), .opA(opA), .opB(opB),
    .immExt(immExt), .aluCode(aluCode), .isShift(isShift), .useImm(useImm),
    .isLink(isLink), .dstIn(dstIn), .exeResult(exeResult), .exeDest(exeDest)
  );

  function automatic logic [31:0] expect_res(logic [31:0] a, logic [31:0] b,
      logic [31:0] imm, logic [3:0] code, logic sh, logic ui, logic lk,
      logic [31:0] pc4);
    logic [31:0] x, y;
    logic [4:0]  n;
    if (lk) return pc4 + 32'd4;
    x = sh ? {27'd0, imm[10:6]} : a;
    y = ui ? imm : b;
    n = x[4:0];
    case (code)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return x ^ y;
      4'd5: return {y[15:0], 16'h0};
      4'd6: return y << n;
      4'd7: return y >> n;
      4'd8: return 32'($signed(y) >>> n);
      default: return 32'd0;
    endcase
  endfunction

  task automatic drive(string tag, logic [31:0] a, logic [31:0] b,
      logic [31:0] imm, logic [3:0] code, logic sh, logic ui, logic lk,
      logic [31:0] pc4, logic [4:0] d);
    @(negedge clk);
    opA = a; opB = b; immExt = imm; aluCode = code; isShift = sh;
    useImm = ui; isLink = lk; pcPlus4 = pc4; dstIn = d;
    expResQ.push_back(expect_res(a, b, imm, code, sh, ui, lk, pc4));
    expDstQ.push_back(lk ? 5'd31 : d);
    tagQ.push_back(tag);
  endtask

  // Monitor: one output per captured input, read 1 ns after the edge (R2).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expResQ.size() > 0) begin
        logic [31:0] er;
        logic [4:0]  ed;
        string       t;
        er = expResQ.pop_front();
        ed = expDstQ.pop_front();
        t  = tagQ.pop_front();
        checks++;
        if (exeResult !== er || exeDest !== ed) begin
          fails++;
          $display("FAIL %s: result %h dest %0d, expected result %h dest %0d",
                   t, exeResult, exeDest, er, ed);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    opA = 32'hDEAD_BEEF; dstIn = 5'd9; isLink = 1'b1; pcPlus4 = 32'h100;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (exeResult !== 32'd0 || exeDest !== 5'd0) begin
      fails++;
      $display("FAIL R1: result %h dest %0d, expected result 0 dest 0", exeResult, exeDest);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R7 add register/immediate, wrap; sub
    drive("R7 add reg",   32'd5, 32'd7, 32'h0, 4'd0, 0, 0, 0, 32'h0, 5'd3);
    drive("R7 R5 add imm",32'd10, 32'hFFFF, 32'hFFFF_FFFF, 4'd0, 0, 1, 0, 32'h0, 5'd4);
    drive("R7 add wrap",  32'hFFFF_FFFF, 32'd1, 32'h0, 4'd0, 0, 0, 0, 32'h0, 5'd5);
    drive("R7 sub",       32'd3, 32'd5, 32'h0, 4'd1, 0, 0, 0, 32'h0, 5'd6);
    // R8 logic ops
    drive("R8 and", 32'hF0F0_1234, 32'h0FF0_FFFF, 32'h0, 4'd2, 0, 0, 0, 32'h0, 5'd7);
    drive("R8 or",  32'hF000_0000, 32'h0000_000F, 32'h0, 4'd3, 0, 0, 0, 32'h0, 5'd8);
    drive("R8 xor imm", 32'h0000_FFFF, 32'h0, 32'h0000_5555, 4'd4, 0, 1, 0, 32'h0, 5'd8);
    // R9 lui
    drive("R9 lui", 32'h1111_1111, 32'h0, 32'h0000_1234, 4'd5, 0, 1, 0, 32'h0, 5'd1);
    // R10/R6 shifts with large opA that must be ignored (shamt field = 15, then 4)
    drive("R10 R6 sll", 32'h0000_001F, 32'hFFFF_FFFF, 32'h0000_03C0, 4'd6, 1, 0, 0, 32'h0, 5'd8);
    drive("R10 srl", 32'h0000_0003, 32'h8000_0000, 32'h0000_0100, 4'd7, 1, 0, 0, 32'h0, 5'd8);
    drive("R10 sra", 32'h0000_0003, 32'h8000_0000, 32'h0000_0100, 4'd8, 1, 0, 0, 32'h0, 5'd8);
    drive("R10 R6 sll by opA", 32'd4, 32'h0000_0001, 32'h0000_07C0, 4'd6, 0, 0, 0, 32'h0, 5'd2);
    // R3 link, including a stray code, operands and destination
    drive("R3 jal at 0x08", 32'h0, 32'h0, 32'h0, 4'd0, 0, 0, 1, 32'h0000_000C, 5'd0);
    drive("R3 link over sub", 32'h1234, 32'h99, 32'h7, 4'd1, 1, 1, 1, 32'h0000_0FFC, 5'd17);
    // R4 destination pass-through right after a link (R2 back-to-back)
    drive("R4 R2 dest after link", 32'd1, 32'd1, 32'h0, 4'd0, 0, 0, 0, 32'h0, 5'd30);
    // R11 unused codes
    drive("R11 code 9",  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 4'd9, 0, 0, 0, 32'h0, 5'd12);
    drive("R11 code 15", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 4'd15, 0, 1, 0, 32'h0, 5'd13);
    @(negedge clk);
    isLink = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule